// File: doc/BRIEF.md
# Dual-Bank Flash Command Controller

This block models the command interface and the timed write engine of a flash memory that has two banks and is erased one block at a time. A small on-chip word array stands in for real cells. The host drives chip-select, output-enable, write-strobe and power-down pins together with an address and 16-bit data. The block samples these pins in its own clock domain and turns each completed bus write into a command. Those commands select what a read returns (array contents, an identifier pair or the status byte), and they start block erase or word program.

Each bank has its own countdown engine. While one bank is erasing or programming, the other bank can still be read at full speed and can still take commands. Any read that lands in the busy bank returns the status byte, and no command is needed for that. Pulling the power-down pin low stops any running operation, puts the interface back in its base state and clears the error bits. The block whose erase or program was cut short is filled with a marker word.

Address map with the default parameters: address bit 6 selects the bank, bits 5:4 select one of four blocks in that bank, and bits 3:0 select one of sixteen words in the block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_n` is released, and after `rp_n` returns high, reads return array data with no command written first.
- R2: A bus write is taken only while `oe_n` is high. Address and data are captured when the first of `we_n` or `ce_n` rises. A strobe with `oe_n` low is ignored.
- R3: Command byte `dq_in[7:0]` 0xFF selects array reads. 0x90 selects identifier reads: an even address returns 0x00A7 and an odd address returns 0x00B3. 0x70 selects status reads, which return `{8'h00, status}`. Any undefined code changes nothing.
- R4: In the status byte, bit 7 is 1 when no bank is busy, bit 5 is the erase error and bit 4 is the program error. All other bits are 0. Command 0x50 clears bits 5:4 and leaves the read mode unchanged.
- R5: Writing 0x20 and then 0xD0 sets all sixteen words of the block addressed by the confirm write to 0xFFFF. Any other second byte sets bits 5 and 4, erases nothing and leaves status reads selected.
- R6: Writing 0x40 and then a data word replaces the addressed word with the old value bitwise-ANDed with the new data. Neighbouring words are not changed.
- R7: `busy_n` is low for exactly 16 clock cycles during a program (and 256 during an erase). An operation runs to the end even if `ce_n` goes high.
- R8: A read whose bank is busy returns the status byte, with bit 7 = 0. A read in the idle bank follows the current read mode. A bus write addressed to a busy bank is dropped.
- R9: While `rp_n` is low, `dq_oe` is low, any running operation stops, and its block is filled with 0x5A5A. Afterwards array reads are selected and the status byte is 0x80. The other bank's contents are not changed.
- R10: `dq_oe` is high only while `rp_n` is high and both `ce_n` and `oe_n` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the host pins |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| rp_n | input | 1 | Power-down and abort, active low |
| addr | input | 7 | Word address: bank, block, word |
| dq_in | input | 16 | Write data; bits 7:0 carry the command byte |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Drive enable for `dq_out`; low means high impedance |
| busy_n | output | 1 | Low while either bank is erasing or programming |

## Verification
The main function is driven from a table of command sequences. That table covers erase followed by reads, and two programs in a row to the same word, which separates an AND merge from a plain overwrite. It also covers identifier reads at even and odd addresses, a wrong confirm byte, sticky and cleared error bits, and an undefined code. Overlap patterns start an erase in one bank and then read both banks and write to the busy bank, which separates the status redirect from normal array reads. Two strobe orderings (`ce_n` rising before `we_n`, and a strobe while `oe_n` is low) check when a write is taken. A power-down in the middle of an erase checks the marker fill, that the other bank is left intact, and that the block returns to array reads and a status of 0x80.

// File: rtl/flash_pkg.sv
package flash_pkg;

   typedef enum logic [1:0] {
      RD_ARRAY  = 2'd0,
      RD_IDENT  = 2'd1,
      RD_STATUS = 2'd2
   } rd_mode_e;

   typedef enum logic [1:0] {
      CUI_IDLE      = 2'd0,
      CUI_ERASE_ARM = 2'd1,
      CUI_PROG_ARM  = 2'd2
   } cui_state_e;

   localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
   localparam logic [7:0] CMD_READ_ID    = 8'h90;
   localparam logic [7:0] CMD_READ_SR    = 8'h70;
   localparam logic [7:0] CMD_CLEAR_SR   = 8'h50;
   localparam logic [7:0] CMD_ERASE      = 8'h20;
   localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
   localparam logic [7:0] CMD_PROGRAM    = 8'h40;

   localparam int DATA_W = 16;

endpackage

// File: rtl/flash_sync.sv
module flash_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4) else $error("flash_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/flash_bank_engine.sv
module flash_bank_engine #(
   parameter int          BLK_BITS  = 2,
   parameter int          WORD_BITS = 4,
   parameter int          PGM_CYC   = 16,
   parameter int          ERASE_CYC = 256,
   parameter logic [15:0] MARKER    = 16'h5A5A
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          abort,
   input  logic                          start_erase,
   input  logic                          start_prog,
   input  logic [BLK_BITS-1:0]           blk_in,
   input  logic [WORD_BITS-1:0]          word_in,
   input  logic [15:0]                   data_in,
   output logic                          busy,
   output logic                          fill_en,
   output logic [BLK_BITS-1:0]           fill_blk,
   output logic [15:0]                   fill_val,
   output logic                          word_en,
   output logic [BLK_BITS+WORD_BITS-1:0] word_addr,
   output logic [15:0]                   word_data
);

   localparam int CNT_W = $clog2(ERASE_CYC + 1);

   initial begin
      assert (PGM_CYC >= 2 && PGM_CYC <= ERASE_CYC) else $error("flash_bank_engine: bad PGM_CYC");
      assert (ERASE_CYC >= (1 << WORD_BITS)) else $error("flash_bank_engine: ERASE_CYC too short");
   end

   logic [CNT_W-1:0]     cnt;
   logic                 is_erase;
   logic [BLK_BITS-1:0]  blk_q;
   logic [WORD_BITS-1:0] word_q;
   logic [15:0]          data_q;
   logic                 finishing;

   assign busy      = (cnt != '0);
   assign finishing = busy && (cnt == CNT_W'(1)) && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         is_erase <= 1'b0;
         blk_q    <= '0;
         word_q   <= '0;
         data_q   <= '0;
      end else if (abort) begin
         cnt <= '0;
      end else if (busy) begin
         cnt <= cnt - CNT_W'(1);
      end else if (start_erase) begin
         cnt      <= CNT_W'(ERASE_CYC);
         is_erase <= 1'b1;
         blk_q    <= blk_in;
      end else if (start_prog) begin
         cnt      <= CNT_W'(PGM_CYC);
         is_erase <= 1'b0;
         blk_q    <= blk_in;
         word_q   <= word_in;
         data_q   <= data_in;
      end
   end

   assign fill_en   = (busy && abort) || (finishing && is_erase);
   assign fill_blk  = blk_q;
   assign fill_val  = abort ? MARKER : 16'hFFFF;
   assign word_en   = finishing && !is_erase;
   assign word_addr = {blk_q, word_q};
   assign word_data = data_q;

   // R8: the top never starts a bank that is still counting
   p_start_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_erase || start_prog) |-> !busy);

   // R7: a running operation counts down by one every cycle
   p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !abort) |=> (cnt == $past(cnt) - CNT_W'(1)));

   // R9: an abort leaves the bank idle on the next cycle
   p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);

endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int NBANK     = 2,
   parameter int BLK_BITS  = 2,
   parameter int WORD_BITS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NBANK-1:0]              fill_en,
   input  logic [BLK_BITS-1:0]           fill_blk  [NBANK],
   input  logic [15:0]                   fill_val  [NBANK],
   input  logic [NBANK-1:0]              word_en,
   input  logic [BLK_BITS+WORD_BITS-1:0] word_addr [NBANK],
   input  logic [15:0]                   word_data [NBANK],
   input  logic [$clog2(NBANK)+BLK_BITS+WORD_BITS-1:0] rd_addr,
   output logic [15:0]                   rd_data
);

   localparam int BANK_BITS = $clog2(NBANK);
   localparam int AW        = BANK_BITS + BLK_BITS + WORD_BITS;
   localparam int DEPTH     = 1 << AW;
   localparam int BLK_WORDS = 1 << WORD_BITS;

   initial begin
      assert (DEPTH <= 4096) else $error("flash_array: array too large");
   end

   logic [15:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int b = 0; b < NBANK; b++) begin
         if (fill_en[b]) begin
            for (int w = 0; w < BLK_WORDS; w++)
               mem[{BANK_BITS'(b), fill_blk[b], WORD_BITS'(w)}] <= fill_val[b];
         end
         if (word_en[b])
            mem[{BANK_BITS'(b), word_addr[b]}] <= mem[{BANK_BITS'(b), word_addr[b]}] & word_data[b];
      end
   end

   assign rd_data = mem[rd_addr];

   generate
      for (genvar gb = 0; gb < NBANK; gb++) begin : g_chk
         // R5 / R9: a block fill reaches the first word of the block
         p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
            fill_en[gb] |=> (mem[{BANK_BITS'(gb), $past(fill_blk[gb]), {WORD_BITS{1'b0}}}]
                             == $past(fill_val[gb])));
      end
   endgenerate

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_pkg::*;
#(
   parameter int          BANKS         = 2,
   parameter int          BLKS_PER_BANK = 4,
   parameter int          BLK_WORDS     = 16,
   parameter int          ADDR_W        = $clog2(BANKS) + $clog2(BLKS_PER_BANK) + $clog2(BLK_WORDS),
   parameter int          PGM_CYC       = 16,
   parameter int          ERASE_CYC     = 256,
   parameter int          SYNC_STAGES   = 2,
   parameter logic [15:0] MFR_CODE      = 16'h00A7,
   parameter logic [15:0] DEV_CODE      = 16'h00B3,
   parameter logic [15:0] ABORT_FILL    = 16'h5A5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              rp_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       dq_in,
   output logic [15:0]       dq_out,
   output logic              dq_oe,
   output logic              busy_n
);

   localparam int BANK_BITS = $clog2(BANKS);
   localparam int BLK_BITS  = $clog2(BLKS_PER_BANK);
   localparam int WORD_BITS = $clog2(BLK_WORDS);
   localparam int LOC_W     = BLK_BITS + WORD_BITS;

   initial begin
      assert (BANKS >= 2 && (1 << BANK_BITS) == BANKS) else $error("flash_cmd_ctrl: BANKS");
      assert ((1 << BLK_BITS) == BLKS_PER_BANK && BLK_BITS >= 1) else $error("flash_cmd_ctrl: BLKS_PER_BANK");
      assert ((1 << WORD_BITS) == BLK_WORDS && WORD_BITS >= 1) else $error("flash_cmd_ctrl: BLK_WORDS");
      assert (ADDR_W == BANK_BITS + LOC_W) else $error("flash_cmd_ctrl: ADDR_W");
   end

   // ---------------- pin sampling ----------------
   logic [3:0] pins_s;
   logic       rp_s, ce_s, we_s, oe_s;

   flash_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rp_n, ce_n, we_n, oe_n}),
      .q     (pins_s)
   );
   assign {rp_s, ce_s, we_s, oe_s} = pins_s;

   logic strobe, strobe_q, commit, accept;
   assign strobe = !ce_s && !we_s && oe_s && rp_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   // the first of the two strobes to rise ends the write
   assign commit = strobe_q && !strobe && rp_s;

   logic [BANK_BITS-1:0] w_bank, r_bank;
   logic [7:0]           cmd;
   logic [BANKS-1:0]     busy_v;

   assign w_bank = addr[ADDR_W-1 -: BANK_BITS];
   assign r_bank = addr[ADDR_W-1 -: BANK_BITS];
   assign cmd    = dq_in[7:0];
   assign accept = commit && !busy_v[w_bank];

   // ---------------- command interface ----------------
   rd_mode_e   mode;
   cui_state_e cui;
   logic [1:0] err;   // [1] erase error, [0] program error

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= RD_ARRAY;
         cui  <= CUI_IDLE;
         err  <= 2'b00;
      end else if (!rp_s) begin
         mode <= RD_ARRAY;
         cui  <= CUI_IDLE;
         err  <= 2'b00;
      end else if (accept) begin
         unique case (cui)
            CUI_IDLE: begin
               case (cmd)
                  CMD_READ_ARRAY: mode <= RD_ARRAY;
                  CMD_READ_ID:    mode <= RD_IDENT;
                  CMD_READ_SR:    mode <= RD_STATUS;
                  CMD_CLEAR_SR:   err  <= 2'b00;
                  CMD_ERASE: begin
                     cui  <= CUI_ERASE_ARM;
                     mode <= RD_STATUS;
                  end
                  CMD_PROGRAM: begin
                     cui  <= CUI_PROG_ARM;
                     mode <= RD_STATUS;
                  end
                  default: ;
               endcase
            end
            CUI_ERASE_ARM: begin
               cui  <= CUI_IDLE;
               mode <= RD_STATUS;
               if (cmd != CMD_CONFIRM) err <= 2'b11;
            end
            CUI_PROG_ARM: begin
               cui  <= CUI_IDLE;
               mode <= RD_STATUS;
            end
            default: cui <= CUI_IDLE;
         endcase
      end
   end

   logic [7:0] sr;
   assign sr = {~|busy_v, 1'b0, err, 4'b0000};

   // ---------------- bank engines ----------------
   logic [BANKS-1:0]     st_er, st_pg, fill_en, word_en;
   logic [BLK_BITS-1:0]  fill_blk  [BANKS];
   logic [15:0]          fill_val  [BANKS];
   logic [LOC_W-1:0]     word_addr [BANKS];
   logic [15:0]          word_data [BANKS];

   generate
      for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
         assign st_er[gb] = accept && (cui == CUI_ERASE_ARM) && (cmd == CMD_CONFIRM)
                            && (w_bank == BANK_BITS'(gb));
         assign st_pg[gb] = accept && (cui == CUI_PROG_ARM) && (w_bank == BANK_BITS'(gb));

         flash_bank_engine #(
            .BLK_BITS  (BLK_BITS),
            .WORD_BITS (WORD_BITS),
            .PGM_CYC   (PGM_CYC),
            .ERASE_CYC (ERASE_CYC),
            .MARKER    (ABORT_FILL)
         ) u_eng (
            .clk         (clk),
            .rst_n       (rst_n),
            .abort       (!rp_s),
            .start_erase (st_er[gb]),
            .start_prog  (st_pg[gb]),
            .blk_in      (addr[WORD_BITS +: BLK_BITS]),
            .word_in     (addr[WORD_BITS-1:0]),
            .data_in     (dq_in),
            .busy        (busy_v[gb]),
            .fill_en     (fill_en[gb]),
            .fill_blk    (fill_blk[gb]),
            .fill_val    (fill_val[gb]),
            .word_en     (word_en[gb]),
            .word_addr   (word_addr[gb]),
            .word_data   (word_data[gb])
         );
      end
   endgenerate

   // ---------------- storage ----------------
   logic [15:0] arr_q;

   flash_array #(
      .NBANK     (BANKS),
      .BLK_BITS  (BLK_BITS),
      .WORD_BITS (WORD_BITS)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fill_en),
      .fill_blk  (fill_blk),
      .fill_val  (fill_val),
      .word_en   (word_en),
      .word_addr (word_addr),
      .word_data (word_data),
      .rd_addr   (addr),
      .rd_data   (arr_q)
   );

   // ---------------- read path ----------------
   always_comb begin
      if (busy_v[r_bank]) begin
         dq_out = {8'h00, sr};
      end else begin
         case (mode)
            RD_ARRAY: dq_out = arr_q;
            RD_IDENT: dq_out = addr[0] ? DEV_CODE : MFR_CODE;
            default:  dq_out = {8'h00, sr};
         endcase
      end
   end

   assign dq_oe  = rp_n && !ce_n && !oe_n;
   assign busy_n = ~|busy_v;

   // R9: power-down returns the interface to its base state
   p_pd_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rp_s |=> (mode == RD_ARRAY && cui == CUI_IDLE && err == 2'b00));

   // R5: a wrong confirm byte raises both error bits
   p_bad_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cui == CUI_ERASE_ARM && cmd != CMD_CONFIRM) |=> (err == 2'b11));

   // R8: a write to a busy bank leaves the interface untouched
   p_busy_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && busy_v[w_bank]) |=> ($stable(mode) && $stable(cui) && $stable(err)));

   // R8: reads of a busy bank carry a not-ready status byte
   p_busy_read_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_v[r_bank] |-> (dq_out[15:7] == 9'd0));

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b0;
   logic [6:0]  addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic        dq_oe, busy_n;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   flash_cmd_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
      .rp_n (rp_n), .addr (addr), .dq_in (dq_in), .dq_out (dq_out),
      .dq_oe (dq_oe), .busy_n (busy_n)
   );

   task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      repeat (4) @(negedge clk);
      ce_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_read(input logic [6:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      #1 d = dq_out;
      oe_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic wait_ready();
      @(negedge clk);
      while (busy_n !== 1'b1) @(negedge clk);
   endtask

   // {op[1:0], addr[6:0], data[15:0], expect[15:0], req[3:0]}; op 0 write, 1 read, 2 wait
   localparam int NV = 36;
   localparam logic [44:0] VEC [NV] = '{
      {2'd0, 7'h00, 16'h0020, 16'h0000, 4'd5},  // R5 erase bank0 blk0
      {2'd0, 7'h00, 16'h00D0, 16'h0000, 4'd5},
      {2'd2, 7'h00, 16'h0000, 16'h0000, 4'd5},
      {2'd0, 7'h40, 16'h0020, 16'h0000, 4'd5},  // R5 erase bank1 blk0
      {2'd0, 7'h40, 16'h00D0, 16'h0000, 4'd5},
      {2'd2, 7'h00, 16'h0000, 16'h0000, 4'd5},
      {2'd0, 7'h00, 16'h00FF, 16'h0000, 4'd3},  // R3 read array
      {2'd1, 7'h05, 16'h0000, 16'hFFFF, 4'd5},  // R5
      {2'd1, 7'h4F, 16'h0000, 16'hFFFF, 4'd5},  // R5
      {2'd0, 7'h05, 16'h0040, 16'h0000, 4'd6},  // R6 first program
      {2'd0, 7'h05, 16'h1234, 16'h0000, 4'd6},
      {2'd2, 7'h00, 16'h0000, 16'h0000, 4'd6},
      {2'd0, 7'h00, 16'h00FF, 16'h0000, 4'd3},
      {2'd1, 7'h05, 16'h0000, 16'h1234, 4'd6},  // R6
      {2'd0, 7'h05, 16'h0040, 16'h0000, 4'd6},  // R6 second program merges
      {2'd0, 7'h05, 16'h0000 | 16'hFF0F, 16'h0000, 4'd6},
      {2'd2, 7'h00, 16'h0000, 16'h0000, 4'd6},
      {2'd0, 7'h00, 16'h00FF, 16'h0000, 4'd3},
      {2'd1, 7'h05, 16'h0000, 16'h1204, 4'd6},  // R6 AND result
      {2'd1, 7'h0F, 16'h0000, 16'hFFFF, 4'd6},  // R6 neighbour intact
      {2'd0, 7'h00, 16'h0090, 16'h0000, 4'd3},  // R3 identifier
      {2'd1, 7'h00, 16'h0000, 16'h00A7, 4'd3},
      {2'd1, 7'h31, 16'h0000, 16'h00B3, 4'd3},
      {2'd0, 7'h00, 16'h0070, 16'h0000, 4'd4},  // R4 status
      {2'd1, 7'h10, 16'h0000, 16'h0080, 4'd4},
      {2'd0, 7'h00, 16'h0020, 16'h0000, 4'd5},  // R5 wrong confirm
      {2'd0, 7'h00, 16'h0055, 16'h0000, 4'd5},
      {2'd1, 7'h00, 16'h0000, 16'h00B0, 4'd5},
      {2'd0, 7'h00, 16'h00FF, 16'h0000, 4'd5},
      {2'd1, 7'h05, 16'h0000, 16'h1204, 4'd5},  // R5 nothing erased
      {2'd0, 7'h00, 16'h0070, 16'h0000, 4'd4},
      {2'd1, 7'h00, 16'h0000, 16'h00B0, 4'd4},  // R4 sticky errors
      {2'd0, 7'h00, 16'h0050, 16'h0000, 4'd4},
      {2'd1, 7'h00, 16'h0000, 16'h0080, 4'd4},  // R4 cleared, mode kept
      {2'd0, 7'h00, 16'h0033, 16'h0000, 4'd3},  // R3 undefined code
      {2'd1, 7'h00, 16'h0000, 16'h0080, 4'd3}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] rd;
      int          lowc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // reset state: power-down held, bus enabled by ce/oe only
      ce_n = 1'b0; oe_n = 1'b0;
      #1;
      check(10, "dq_oe during power-down", {15'd0, dq_oe}, 16'h0000);   // R10
      check(7, "busy_n after reset", {15'd0, busy_n}, 16'h0001);        // R7
      ce_n = 1'b1; oe_n = 1'b1;
      rp_n = 1'b1;
      repeat (4) @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b1;
      #1 check(10, "dq_oe with oe_n high", {15'd0, dq_oe}, 16'h0000);   // R10
      ce_n = 1'b1; oe_n = 1'b0;
      #1 check(10, "dq_oe with ce_n high", {15'd0, dq_oe}, 16'h0000);   // R10
      ce_n = 1'b0;
      #1 check(10, "dq_oe when selected", {15'd0, dq_oe}, 16'h0001);    // R10
      ce_n = 1'b1; oe_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [44:0] v;
         v = VEC[i];
         case (v[44:43])
            2'd0: bus_write(v[42:36], v[35:20]);
            2'd1: begin
               bus_read(v[42:36], rd);
               check(int'(v[3:0]), $sformatf("vector %0d", i), rd, v[19:4]);
            end
            default: wait_ready();
         endcase
      end

      // R2: ce_n rises before we_n; data changes afterwards
      @(negedge clk);
      addr = 7'h00; dq_in = 16'h0090; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      ce_n = 1'b1;
      repeat (4) @(negedge clk);
      dq_in = 16'h00FF;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(7'h01, rd);
      check(2, "capture on first rising strobe", rd, 16'h00B3);          // R2
      // R2: strobe with oe_n low is ignored
      @(negedge clk);
      addr = 7'h00; dq_in = 16'h0070; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      repeat (4) @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_read(7'h00, rd);
      check(2, "write with oe_n low ignored", rd, 16'h00A7);             // R2

      // R8: erase bank1 blk1, read both banks meanwhile
      bus_write(7'h50, 16'h0020);
      bus_write(7'h50, 16'h00D0);
      bus_write(7'h00, 16'h00FF);
      check(7, "busy_n during erase", {15'd0, busy_n}, 16'h0000);        // R7
      bus_read(7'h05, rd);
      check(8, "idle bank reads array", rd, 16'h1204);                   // R8
      bus_read(7'h50, rd);
      check(8, "busy bank reads status", rd, 16'h0000);                  // R8
      bus_write(7'h55, 16'h0090);
      bus_read(7'h05, rd);
      check(8, "write to busy bank dropped", rd, 16'h1204);              // R8
      wait_ready();
      bus_read(7'h55, rd);
      check(5, "bank1 blk1 erased", rd, 16'hFFFF);                       // R5

      // R7: program length with chip deselected during the run
      @(negedge clk);
      addr = 7'h06; dq_in = 16'h0040; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      repeat (4) @(negedge clk);
      ce_n = 1'b1;
      repeat (2) @(negedge clk);
      addr = 7'h06; dq_in = 16'h00F0; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      lowc = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (c == 1) ce_n = 1'b1;
         if (busy_n === 1'b0) lowc++;
      end
      check(7, "program busy cycles", 16'(lowc), 16'd16);                // R7
      bus_write(7'h00, 16'h00FF);
      bus_read(7'h06, rd);
      check(6, "program while deselected", rd, 16'h00F0);                // R6 R7

      // R9: power-down in the middle of an erase of bank0 blk0
      bus_write(7'h00, 16'h0020);
      bus_write(7'h00, 16'h00D0);
      repeat (20) @(negedge clk);
      rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      check(9, "dq_oe in power-down", {15'd0, dq_oe}, 16'h0000);         // R9
      check(9, "busy_n after abort", {15'd0, busy_n}, 16'h0001);         // R9
      ce_n = 1'b1; oe_n = 1'b1;
      rp_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(7'h05, rd);
      check(1, "array read after power-down, marker", rd, 16'h5A5A);     // R1 R9
      bus_read(7'h55, rd);
      check(9, "other bank intact", rd, 16'hFFFF);                       // R9
      bus_write(7'h00, 16'h0070);
      bus_read(7'h00, rd);
      check(9, "status after power-down", rd, 16'h0080);                 // R9

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule